// File: doc/BRIEF.md
# Floppy Controller Enhanced-Mode Register Bank

This block is the register set a dual-mode floppy controller shows once it has been switched into its enhanced mode. It sits on a byte-wide bus. It decodes a four-bit register index taken from address bits 12 down to 9. It keeps four pieces of state:

- a phase byte that drives the drive-control lines;
- a mode byte, changed through two addresses: one clears bits and one sets bits;
- a 16-entry parameter memory whose pointer steps forward on every access;
- a drive-present answer given through a handshake read.

A pulse on `enterEnh` marks the switch into enhanced mode. When software clears the enhanced-mode bit of the mode byte, the block sends a one-cycle `leaveEnh` pulse so the surrounding controller can return to its legacy register set.

Only the address bits that carry the index are brought in, so the `regAddr` port is declared with bit range [12:9]. A read result appears on `rdData` one cycle after the read strobe. `rdData` then holds that value until the next read.

Top module: `flp_enh_regs`

## Requirements
- R1: Index values 0–7 are write registers, taken on `wrEn`. Index values 8–15 are read registers, taken on `rdEn`. If `wrEn` and `rdEn` are high together, only the write happens and `rdData` keeps its value. A read strobe with an index below 8 loads 0 into `rdData`.
- R2: A write to index 6 clears every bit of `modeBits` that is 1 in `wrData`. The other bits keep their values.
- R3: A write to index 7 sets every bit of `modeBits` that is 1 in `wrData`. The other bits keep their values.
- R4: A write to index 6 returns the parameter pointer to entry 0, whatever the data.
- R5: `leaveEnh` is high for exactly the one cycle after a write to index 6 that leaves mode bit 6 at 0. At all other times it is low.
- R6: A write to index 3 stores `wrData` at the pointer. A read of index 11 returns the entry at the pointer. Each of these accesses then advances the pointer by one, and entry 15 wraps to entry 0.
- R7: A write to index 4 stores the phase byte. A read of index 12 returns it.
- R8: A read of index 15 returns 0x08 when the phase byte equals 0x77, and 0x00 otherwise.
- R9: A read of index 14 returns 0x40 while mode bit 6 is 1, and 0x00 while it is 0.
- R10: An `enterEnh` pulse sets mode bit 6. If the same cycle has an index-6 write that clears bit 6, the set wins and no `leaveEnh` follows.
- R11: After reset, `modeBits`, the phase byte, the pointer, `rdData` and `leaveEnh` are all 0.
- R12: Writes to indices 0, 1, 2 and 5 change no state. Reads of indices 8, 9, 10 and 13 return 0 and change no state.
- R13: `rdData` is loaded on the clock edge where a read is taken. It stays unchanged on every cycle that takes no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| regAddr | input | 4 ([12:9]) | Register index bits of the bus address |
| wrData | input | 8 | Write data |
| enterEnh | input | 1 | Pulse that sets mode bit 6 |
| rdData | output | 8 | Registered read result |
| modeBits | output | 8 | Current mode byte |
| leaveEnh | output | 1 | One-cycle pulse requesting the legacy register set |

## Verification
Directed sequences check the cases that random stimulus would rarely reach:

- filling all sixteen parameter entries and then reading seventeen, so the wrap back to entry 0 shows;
- an index-6 write in the middle of the table, showing that the pointer reset is separate from any data;
- phase values 0x77 and 0x76, telling the drive-present match apart from a near miss;
- an `enterEnh` pulse in the same cycle as a clear of bit 6, showing which one wins.

Seeded random traffic then mixes every index, collisions of both strobes, and random mode masks. Each result is compared with a bench model of the mode byte, phase byte, pointer and table. This shows that the ignored registers really leave the state alone and that the pointer stays in step across reads and writes.

// File: rtl/flp_enh_pkg.sv
package flp_enh_pkg;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = 4;
  localparam int IDX_LSB    = 9;
  localparam int PRAM_DEPTH = 16;
  localparam int ENH_BIT    = 6;
  localparam logic [DATA_W-1:0] DRIVE_QUERY = 8'h77;
  localparam logic [DATA_W-1:0] SENSE_VAL   = 8'h08;

  typedef enum logic [2:0] {
    RD_ZERO, RD_PARAM, RD_PHASE, RD_STATUS, RD_HSHAKE
  } rdSel_e;

  typedef struct packed {
    logic   wrParam;
    logic   wrPhase;
    logic   modeClr;
    logic   modeSet;
    logic   rdLoad;
    logic   rdParam;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/flp_enh_ctrl.sv
module flp_enh_ctrl
  import flp_enh_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] idx,
  output strobe_t          st
);
  logic takeRd;
  assign takeRd = rdEn && !wrEn;

  always_comb begin
    st = '0;
    st.rdSel = RD_ZERO;
    if (wrEn) begin
      unique case (idx)
        4'd3:    st.wrParam = 1'b1;
        4'd4:    st.wrPhase = 1'b1;
        4'd6:    st.modeClr = 1'b1;
        4'd7:    st.modeSet = 1'b1;
        default: ;
      endcase
    end
    if (takeRd) begin
      st.rdLoad = 1'b1;
      unique case (idx)
        4'd11: begin st.rdSel = RD_PARAM; st.rdParam = 1'b1; end
        4'd12:   st.rdSel = RD_PHASE;
        4'd14:   st.rdSel = RD_STATUS;
        4'd15:   st.rdSel = RD_HSHAKE;
        default: st.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/flp_enh_dp.sv
module flp_enh_dp
  import flp_enh_pkg::*;
#(
  parameter int DEPTH = PRAM_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              enterEnh,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] modeQ,
  output logic [DATA_W-1:0] phaseQ,
  output logic              leaveQ
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] pram [DEPTH];
  logic [PTR_W-1:0]  ptrQ, ptrInc;
  logic [DATA_W-1:0] modeNext, rdNext;

  assign ptrInc = (ptrQ == PTR_LAST) ? '0 : ptrQ + 1'b1;

  always_comb begin
    modeNext = modeQ;
    if (st.modeClr) modeNext = modeNext & ~wrData;
    if (st.modeSet) modeNext = modeNext | wrData;
    if (enterEnh)   modeNext[ENH_BIT] = 1'b1;
  end

  always_comb begin
    rdNext = '0;
    unique case (st.rdSel)
      RD_PARAM:  rdNext = pram[ptrQ];
      RD_PHASE:  rdNext = phaseQ;
      RD_STATUS: rdNext[ENH_BIT] = modeQ[ENH_BIT];
      RD_HSHAKE: rdNext = (phaseQ == DRIVE_QUERY) ? SENSE_VAL : '0;
      default:   rdNext = '0;
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk)
      if (st.wrParam && ptrQ == PTR_W'(g)) pram[g] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= '0;
      phaseQ <= '0;
      ptrQ   <= '0;
      rdData <= '0;
      leaveQ <= 1'b0;
    end else begin
      modeQ  <= modeNext;
      leaveQ <= st.modeClr && !modeNext[ENH_BIT];
      if (st.wrPhase) phaseQ <= wrData;
      if (st.modeClr) ptrQ <= '0;
      else if (st.wrParam || st.rdParam) ptrQ <= ptrInc;
      if (st.rdLoad) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/flp_enh_regs.sv
module flp_enh_regs
  import flp_enh_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic                             rdEn,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB]   regAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             enterEnh,
  output logic [DATA_W-1:0]                rdData,
  output logic [DATA_W-1:0]                modeBits,
  output logic                             leaveEnh
);
  strobe_t           st;
  logic [DATA_W-1:0] phaseQ;

  flp_enh_ctrl u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .idx(regAddr), .st(st)
  );

  flp_enh_dp #(.DEPTH(PRAM_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .enterEnh(enterEnh),
    .rdData(rdData), .modeQ(modeBits), .phaseQ(phaseQ), .leaveQ(leaveEnh)
  );
endmodule

// File: rtl/flp_enh_chk.sv
module flp_enh_chk
  import flp_enh_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [IDX_W-1:0]  idx,
  input logic [DATA_W-1:0] wrData,
  input logic              enterEnh,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] modeBits,
  input logic              leaveEnh,
  input logic [DATA_W-1:0] phaseQ
);
  logic clrWr, rdOnly;
  assign clrWr  = wrEn && idx == 4'd6;
  assign rdOnly = rdEn && !wrEn;

  assert_leave_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    clrWr && wrData[ENH_BIT] && !enterEnh |=> leaveEnh && !modeBits[ENH_BIT]);
  assert_no_stray_leave_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> !leaveEnh);
  assert_enter_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    enterEnh |=> modeBits[ENH_BIT] && !leaveEnh);
  assert_handshake_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdOnly && idx == 4'd15 |=> rdData == (($past(phaseQ) == DRIVE_QUERY) ? SENSE_VAL : 8'h00));
  assert_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdOnly && idx == 4'd14 |=> rdData == {1'b0, $past(modeBits[ENH_BIT]), 6'b0});
  assert_zero_reads_R12: assert property (@(posedge clk) disable iff (!rstN)
    rdOnly && (idx == 4'd8 || idx == 4'd9 || idx == 4'd10 || idx == 4'd13 || idx < 4'd8)
    |=> rdData == 8'h00);
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !rdOnly |=> $stable(rdData));
  assert_mode_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !enterEnh && !(wrEn && (idx == 4'd6 || idx == 4'd7)) |=> $stable(modeBits));
endmodule

bind flp_enh_regs flp_enh_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .idx(regAddr),
  .wrData(wrData), .enterEnh(enterEnh), .rdData(rdData),
  .modeBits(modeBits), .leaveEnh(leaveEnh), .phaseQ(phaseQ)
);

// File: tb/sim_flp_enh_regs.sv
module sim_flp_enh_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, enterEnh = 1'b0;
  logic [12:9] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, modeBits;
  logic       leaveEnh;

  int checks = 0, fails = 0;
  logic [7:0] mMode = 0, mPhase = 0, mRd = 0;
  logic [7:0] mPram [16];
  int         mPtr = 0;
  logic       mLeave = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  flp_enh_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .enterEnh(enterEnh), .rdData(rdData),
    .modeBits(modeBits), .leaveEnh(leaveEnh)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hsExp(logic [7:0] ph);
    return (ph == 8'h77) ? 8'h08 : 8'h00;
  endfunction

  // one bus cycle; inputs set after negedge, results checked at next negedge
  task automatic step(bit wr, bit rd, int idx, logic [7:0] d, bit ent, string req);
    logic [7:0] nm;
    bit took;
    wrEn = wr; rdEn = rd; regAddr = idx[3:0]; wrData = d; enterEnh = ent;
    nm = mMode; took = 0;
    if (wr) begin
      case (idx)
        3: begin mPram[mPtr] = d; mPtr = (mPtr + 1) % 16; end
        4: mPhase = d;
        6: begin nm = mMode & ~d; mPtr = 0; end
        7: nm = mMode | d;
        default: ;
      endcase
    end else if (rd) begin
      took = 1;
      case (idx)
        11: begin mRd = mPram[mPtr]; mPtr = (mPtr + 1) % 16; end
        12: mRd = mPhase;
        14: mRd = {1'b0, mMode[6], 6'b0};
        15: mRd = hsExp(mPhase);
        default: mRd = 8'h00;
      endcase
    end
    if (ent) nm[6] = 1'b1;
    mLeave = wr && idx == 6 && !nm[6];
    mMode = nm;
    @(negedge clk);
    wrEn = 0; rdEn = 0; enterEnh = 0;
    chk({req, " mode R2 R3 R10"}, modeBits, mMode);
    chk({req, " leave R5"}, {7'b0, leaveEnh}, {7'b0, mLeave});
    chk({req, " rdData R13"}, rdData, mRd);
    if (took) checks += 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 mode after reset", modeBits, 8'h00);
    chk("R11 leave after reset", {7'b0, leaveEnh}, 8'h00);
    chk("R11 rdData after reset", rdData, 8'h00);
    step(0, 1, 12, 0, 0, "R11 phase reads 0");
    step(0, 1, 14, 0, 0, "R9 status idle");

    step(0, 0, 0, 0, 1, "R10 enter");
    step(0, 1, 14, 0, 0, "R9 status enhanced");
    step(1, 0, 7, 8'h85, 0, "R3 set mask");
    step(1, 0, 6, 8'h04, 0, "R2 clear mask keeps bit6");
    step(1, 0, 6, 8'h40, 1, "R10 enter beats clear");
    step(1, 0, 6, 8'h41, 0, "R5 clear bit6");
    step(1, 0, 6, 8'h00, 0, "R5 clear while bit6 low");

    for (int i = 0; i < 16; i++) step(1, 0, 3, 8'(i * 17 + 3), 0, "R6 fill");
    for (int i = 0; i < 17; i++) step(0, 1, 11, 0, 0, "R6 read wrap");
    step(0, 1, 11, 0, 0, "R6 advance");
    step(1, 0, 6, 8'h00, 0, "R4 pointer reset");
    step(0, 1, 11, 0, 0, "R4 entry 0 after reset");

    step(1, 0, 4, 8'h77, 0, "R7 phase write");
    step(0, 1, 15, 0, 0, "R8 drive present");
    step(0, 1, 12, 0, 0, "R7 phase read");
    step(1, 0, 4, 8'h76, 0, "R7 phase write");
    step(0, 1, 15, 0, 0, "R8 near miss");

    foreach (mPram[i]) if (i < 0) mPram[i] = 0;
    step(1, 0, 0, 8'hff, 0, "R12 write data ignored");
    step(1, 0, 5, 8'hff, 0, "R12 write setup ignored");
    step(0, 1, 9, 0, 0, "R12 read mark zero");
    step(0, 1, 13, 0, 0, "R12 read setup zero");
    step(0, 1, 2, 0, 0, "R1 read low index zero");
    step(1, 1, 12, 8'h11, 0, "R1 write wins over read");
    step(0, 1, 12, 0, 0, "R7 phase unchanged");

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r < 5, r >= 3, int'($urandom_range(0, 15)), 8'($urandom),
           ($urandom_range(0, 19) == 0), "R1 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule